// File: doc/BRIEF.md
# Multiplexed-Address Video DRAM Front End

This block sits in front of the storage of a dual-ported video memory. One nine-bit address bus carries both halves of a word address. A row strobe marks the row half and a column strobe marks the column half. Both strobes are active low and both are sampled on the system clock. On the clock edge where the row strobe is first seen low, the block stores the row address. In the same edge it freezes the operation-select levels: the column-strobe level, the special-function select, the transfer enable, both byte write enables and the data bus. The cycle type comes only from these frozen levels.

The block supports five cycle types: a plain read, a masked write, an eight-column block write, a colour-register load and a register transfer. In a block write the low three column bits are dropped. One column strobe then fills up to eight adjacent columns with the colour value, under a per-column mask that is taken from the data bus. The storage is a small register array. Only the low address bits index it, so the array can be checked against a reference model. When the row strobe rises, the cycle ends and the block returns to idle.

Top module: `vdram_front`

## Requirements
- R1: After reset, op_o is 0 (idle), row_o, col_o and byte_en_o are 0, and data_oe_o is low.
- R2: When the row strobe falls, row_o takes addr_i. op_o is decoded from the levels frozen in that same edge, checked in this priority order: transfer enable low gives 5 (transfer); otherwise special select high gives 3 (block write) if the column strobe is high, or 4 (colour load) if it is low; otherwise either write enable low gives 2 (write); otherwise the result is 1 (read).
- R3: While the row strobe stays low, op_o does not change, whatever the control inputs do.
- R4: In a read, write or transfer cycle, the column strobe falling latches addr_i onto col_o.
- R5: In a block cycle, col_o shows the column with bits 2:0 forced to zero. For each bit k of data_i[7:0] that is set at the column strobe, column (block*8 + k) of the open row is loaded with the colour register. Only the byte lanes whose write enable was low at the row strobe are written.
- R6: A write cycle stores data_i, as seen at the column strobe, into the array word at the low ARR_ROW_W row bits and the low ARR_COL_W column bits. A bit changes only where two conditions both hold: the data bus bit was 1 at the row strobe (bit mask), and the bit's byte lane was enabled. Bits 15:8 use we_hi_ni and bits 7:0 use we_lo_ni. byte_en_o is {~we_hi_ni, ~we_lo_ni} as frozen at the row strobe.
- R7: In a read cycle, data_o holds the addressed word from the column-strobe edge onward. data_oe_o is high only while the cycle is a read, a column has been strobed, and the transfer enable is low.
- R8: A colour-load cycle writes data_i, taken at the row strobe, into the colour register, one byte lane per enabled write enable.
- R9: One clock after the row strobe rises, op_o, row_o, col_o and byte_en_o return to 0.
- R10: A transfer cycle leaves the array unchanged, latches the tap column onto col_o, and never asserts data_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 9 | Multiplexed row/column address |
| row_strobe_ni | input | 1 | Row strobe, active low |
| col_strobe_ni | input | 1 | Column strobe, active low |
| fsel_i | input | 1 | Special-function select |
| xfer_en_ni | input | 1 | Transfer enable; output enable in normal cycles |
| we_hi_ni | input | 1 | Upper-byte write enable, active low |
| we_lo_ni | input | 1 | Lower-byte write enable, active low |
| data_i | input | 16 | Data bus in (bit mask, write data, colour, block mask) |
| row_o | output | 9 | Latched row address |
| col_o | output | 9 | Latched column or block address |
| op_o | output | 3 | Decoded cycle type |
| byte_en_o | output | 2 | Active byte lanes {upper, lower} |
| data_o | output | 16 | Read data |
| data_oe_o | output | 1 | Read data valid on the bus |

## Verification
The bench builds the block with the default geometry: 4 rows by 32 columns of 16-bit words, which is four eight-column blocks per row. At this size a bench-side copy of the whole array is kept, and every written column can be read back. Block writes at the first and the last block of a row are covered, together with masks that reach both edge columns of a block. Upper address bits are given non-zero values in some cycles, which shows that only the low bits select a word.

// File: rtl/vdram_pkg.sv
package vdram_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_READ  = 3'd1,
    OP_WRITE = 3'd2,
    OP_BLOCK = 3'd3,
    OP_COLOR = 3'd4,
    OP_XFER  = 3'd5
  } vdram_op_e;
endpackage

// File: rtl/vdram_row_latch.sv
module vdram_row_latch
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  logic              fsel_i,
  input  logic              xfer_en_ni,
  input  logic              we_hi_ni,
  input  logic              we_lo_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] row_o,
  output vdram_op_e         op_o,
  output logic [1:0]        be_o,
  output logic [DATA_W-1:0] bitmask_o,
  output logic [DATA_W-1:0] color_o
);
  localparam int HALF = DATA_W / 2;

  logic      row_prev_q, row_fall, row_rise;
  vdram_op_e op_d;

  assign row_fall = row_prev_q & ~row_strobe_ni;
  assign row_rise = ~row_prev_q & row_strobe_ni;

  always_comb begin
    if (!xfer_en_ni)               op_d = OP_XFER;
    else if (fsel_i)               op_d = col_strobe_ni ? OP_BLOCK : OP_COLOR;
    else if (!we_hi_ni || !we_lo_ni) op_d = OP_WRITE;
    else                           op_d = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_prev_q <= 1'b1;
      row_o      <= '0;
      op_o       <= OP_IDLE;
      be_o       <= '0;
      bitmask_o  <= '0;
      color_o    <= '0;
    end else begin
      row_prev_q <= row_strobe_ni;
      if (row_fall) begin
        row_o     <= addr_i;
        op_o      <= op_d;
        be_o      <= {~we_hi_ni, ~we_lo_ni};
        bitmask_o <= (op_d == OP_WRITE) ? data_i : '1;
        if (op_d == OP_COLOR) begin
          if (!we_hi_ni) color_o[DATA_W-1:HALF] <= data_i[DATA_W-1:HALF];
          if (!we_lo_ni) color_o[HALF-1:0]      <= data_i[HALF-1:0];
        end
      end else if (row_rise) begin
        row_o     <= '0;
        op_o      <= OP_IDLE;
        be_o      <= '0;
        bitmask_o <= '0;
      end
    end
  end
endmodule

// File: rtl/vdram_col_stage.sv
module vdram_col_stage
  import vdram_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int BLK_LSB = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  vdram_op_e         op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              col_fall_o,
  output logic [ADDR_W-1:0] col_o,
  output logic              col_seen_o
);
  logic col_prev_q, active;

  assign active     = (op_i != OP_IDLE) && !row_strobe_ni;
  assign col_fall_o = col_prev_q & ~col_strobe_ni & active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_prev_q <= 1'b1;
      col_o      <= '0;
      col_seen_o <= 1'b0;
    end else begin
      col_prev_q <= col_strobe_ni;
      if (col_fall_o) begin
        col_o      <= (op_i == OP_BLOCK) ? {addr_i[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}} : addr_i;
        col_seen_o <= 1'b1;
      end else if (!active) begin
        col_o      <= '0;
        col_seen_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vdram_array.sv
module vdram_array #(
  parameter int DATA_W  = 16,
  parameter int ROW_W   = 2,
  parameter int COL_W   = 5,
  parameter int BLK_LSB = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_word_i,
  input  logic                    wr_block_i,
  input  logic [ROW_W-1:0]        row_i,
  input  logic [COL_W-1:0]        col_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [DATA_W-1:0]       bitmask_i,
  input  logic [1:0]              be_i,
  input  logic [(1<<BLK_LSB)-1:0] blk_mask_i,
  input  logic [DATA_W-1:0]       color_i,
  output logic [DATA_W-1:0]       rdata_o
);
  localparam int ROWS     = 1 << ROW_W;
  localparam int COLS     = 1 << COL_W;
  localparam int BLK_COLS = 1 << BLK_LSB;
  localparam int HALF     = DATA_W / 2;

  logic [DATA_W-1:0] mem_q [ROWS][COLS];
  logic [DATA_W-1:0] lanes, word_m;

  assign lanes   = {{HALF{be_i[1]}}, {HALF{be_i[0]}}};
  assign word_m  = bitmask_i & lanes;
  assign rdata_o = mem_q[row_i][col_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          mem_q[r][c] <= '0;
    end else if (wr_word_i) begin
      mem_q[row_i][col_i] <= (mem_q[row_i][col_i] & ~word_m) | (wdata_i & word_m);
    end else if (wr_block_i) begin
      for (int k = 0; k < BLK_COLS; k++)
        if (blk_mask_i[k])
          mem_q[row_i][{col_i[COL_W-1:BLK_LSB], BLK_LSB'(k)}] <=
            (mem_q[row_i][{col_i[COL_W-1:BLK_LSB], BLK_LSB'(k)}] & ~lanes) | (color_i & lanes);
    end
  end
endmodule

// File: rtl/vdram_front.sv
module vdram_front
  import vdram_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int ARR_ROW_W = 2,
  parameter int ARR_COL_W = 5,
  parameter int BLK_COLS  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              row_strobe_ni,
  input  logic              col_strobe_ni,
  input  logic              fsel_i,
  input  logic              xfer_en_ni,
  input  logic              we_hi_ni,
  input  logic              we_lo_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic [2:0]        op_o,
  output logic [1:0]        byte_en_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int BLK_LSB = $clog2(BLK_COLS);

  vdram_op_e         op_q;
  logic [DATA_W-1:0] bitmask_q, color_q, rdata;
  logic              col_fall, col_seen;

  vdram_row_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_row (
    .clk_i, .rst_ni, .row_strobe_ni, .col_strobe_ni, .fsel_i, .xfer_en_ni,
    .we_hi_ni, .we_lo_ni, .addr_i, .data_i,
    .row_o, .op_o(op_q), .be_o(byte_en_o), .bitmask_o(bitmask_q), .color_o(color_q)
  );

  vdram_col_stage #(.ADDR_W(ADDR_W), .BLK_LSB(BLK_LSB)) u_col (
    .clk_i, .rst_ni, .row_strobe_ni, .col_strobe_ni, .op_i(op_q), .addr_i,
    .col_fall_o(col_fall), .col_o, .col_seen_o(col_seen)
  );

  vdram_array #(
    .DATA_W(DATA_W), .ROW_W(ARR_ROW_W), .COL_W(ARR_COL_W), .BLK_LSB(BLK_LSB)
  ) u_arr (
    .clk_i, .rst_ni,
    .wr_word_i (col_fall && op_q == OP_WRITE),
    .wr_block_i(col_fall && op_q == OP_BLOCK),
    .row_i     (row_o[ARR_ROW_W-1:0]),
    .col_i     (addr_i[ARR_COL_W-1:0]),
    .wdata_i   (data_i),
    .bitmask_i (bitmask_q),
    .be_i      (byte_en_o),
    .blk_mask_i(data_i[BLK_COLS-1:0]),
    .color_i   (color_q),
    .rdata_o   (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         data_o <= '0;
    else if (col_fall && op_q == OP_READ) data_o <= rdata;
  end

  assign op_o      = op_q;
  assign data_oe_o = (op_q == OP_READ) && col_seen && !xfer_en_ni;
endmodule

// File: rtl/vdram_front_chk.sv
module vdram_front_chk
  import vdram_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              row_strobe_ni,
  input logic              col_strobe_ni,
  input logic              xfer_en_ni,
  input logic [ADDR_W-1:0] row_o,
  input logic [ADDR_W-1:0] col_o,
  input logic [2:0]        op_o,
  input logic              data_oe_o
);
  a_r2_row_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(row_strobe_ni) |=> row_o == $past(addr_i));

  a_r2_xfer_decode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(row_strobe_ni) && !xfer_en_ni) |=> op_o == OP_XFER);

  a_r3_op_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!row_strobe_ni && $past(!row_strobe_ni) && $past(!row_strobe_ni, 2)) |-> $stable(op_o));

  a_r4_col_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(col_strobe_ni) && !row_strobe_ni &&
     (op_o == OP_READ || op_o == OP_WRITE || op_o == OP_XFER)) |=> col_o == $past(addr_i));

  a_r5_block_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_BLOCK) |-> col_o[2:0] == 3'd0);

  a_r9_idle_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(row_strobe_ni) |=> op_o == OP_IDLE);

  a_r10_xfer_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_XFER) |-> !data_oe_o);
endmodule

bind vdram_front vdram_front_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_vdram_front.sv
`timescale 1ns/1ps
module tb_vdram_front;
  logic        clk_i = 0, rst_ni = 0;
  logic [8:0]  addr_i = '0;
  logic        row_strobe_ni = 1, col_strobe_ni = 1, fsel_i = 0;
  logic        xfer_en_ni = 1, we_hi_ni = 1, we_lo_ni = 1;
  logic [15:0] data_i = '0;
  logic [8:0]  row_o, col_o;
  logic [2:0]  op_o;
  logic [1:0]  byte_en_o;
  logic [15:0] data_o;
  logic        data_oe_o;

  int tests = 0, fails = 0;
  logic [15:0] ref_mem [4][32];
  logic [15:0] color = '0;

  always #4 clk_i = ~clk_i;

  vdram_front dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic row_open(input logic [8:0] a, input logic fs, input logic xn,
                          input logic whn, input logic wln, input logic cas, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; fsel_i = fs; xfer_en_ni = xn; we_hi_ni = whn; we_lo_ni = wln;
    col_strobe_ni = cas; data_i = d; row_strobe_ni = 0;
    @(negedge clk_i);
    chk(row_o == a, "R2 row", row_o, a);
  endtask

  task automatic col_pulse(input logic [8:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; data_i = d; col_strobe_ni = 0;
    @(negedge clk_i);
  endtask

  task automatic row_close();
    @(negedge clk_i);
    row_strobe_ni = 1; col_strobe_ni = 1; fsel_i = 0; xfer_en_ni = 1;
    we_hi_ni = 1; we_lo_ni = 1;
    @(negedge clk_i);
    chk(op_o == 0 && row_o == 0 && col_o == 0 && byte_en_o == 0, "R9 idle",
        {op_o, row_o, col_o, byte_en_o}, 0);
  endtask

  task automatic do_write(input logic [8:0] r, input logic [8:0] c, input logic whn,
                          input logic wln, input logic [15:0] mask, input logic [15:0] d);
    logic [15:0] m;
    row_open(r, 0, 1, whn, wln, 1, mask);
    chk(op_o == 2, "R2 write decode", op_o, 2);
    chk(byte_en_o == {~whn, ~wln}, "R6 byte_en", byte_en_o, {~whn, ~wln});
    col_pulse(c, d);
    chk(col_o == c, "R4 col", col_o, c);
    m = mask & {{8{~whn}}, {8{~wln}}};
    ref_mem[r[1:0]][c[4:0]] = (ref_mem[r[1:0]][c[4:0]] & ~m) | (d & m);
    row_close();
  endtask

  task automatic do_read(input logic [8:0] r, input logic [8:0] c, input string req);
    row_open(r, 0, 1, 1, 1, 1, 16'h0);
    chk(op_o == 1, "R2 read decode", op_o, 1);
    col_pulse(c, 16'h0);
    chk(data_oe_o == 0, "R7 oe off", data_oe_o, 0);
    xfer_en_ni = 0;
    #1;
    chk(data_oe_o == 1, "R7 oe on", data_oe_o, 1);
    chk(data_o == ref_mem[r[1:0]][c[4:0]], req, data_o, ref_mem[r[1:0]][c[4:0]]);
    row_close();
  endtask

  task automatic load_color(input logic whn, input logic wln, input logic [15:0] d);
    row_open(9'h000, 1, 1, whn, wln, 0, d);
    chk(op_o == 4, "R8 colour decode", op_o, 4);
    if (!whn) color[15:8] = d[15:8];
    if (!wln) color[7:0] = d[7:0];
    row_close();
  endtask

  task automatic block_write(input logic [8:0] r, input logic [8:0] c, input logic whn,
                             input logic wln, input logic [7:0] bm);
    logic [15:0] ln;
    row_open(r, 1, 1, whn, wln, 1, 16'h0);
    chk(op_o == 3, "R5 block decode", op_o, 3);
    col_pulse(c, {8'h00, bm});
    chk(col_o == {c[8:3], 3'b000}, "R5 block col", col_o, {c[8:3], 3'b000});
    ln = {{8{~whn}}, {8{~wln}}};
    for (int k = 0; k < 8; k++)
      if (bm[k]) ref_mem[r[1:0]][{c[4:3], 3'(k)}] =
        (ref_mem[r[1:0]][{c[4:3], 3'(k)}] & ~ln) | (color & ln);
    row_close();
  endtask

  task automatic t_reset();
    chk(op_o == 0 && row_o == 0 && col_o == 0 && byte_en_o == 0, "R1 reset outputs",
        {op_o, row_o, col_o, byte_en_o}, 0);
    chk(data_oe_o == 0, "R1 reset oe", data_oe_o, 0);
  endtask

  task automatic t_write_read();
    do_write(9'h101, 9'h005, 0, 0, 16'hFFFF, 16'hA5C3);
    do_read(9'h001, 9'h005, "R6 full write");
    do_write(9'h001, 9'h105, 1, 0, 16'h0F0F, 16'h1234);
    do_read(9'h101, 9'h005, "R6 masked lower byte");
    do_write(9'h003, 9'h01F, 0, 1, 16'hFF00, 16'h7E00);
    do_read(9'h003, 9'h01F, "R6 upper byte only");
  endtask

  task automatic t_frozen();
    row_open(9'h002, 0, 1, 1, 1, 1, 16'h0);
    fsel_i = 1; we_hi_ni = 0; we_lo_ni = 0;
    repeat (3) @(negedge clk_i);
    chk(op_o == 1, "R3 op frozen", op_o, 1);
    chk(byte_en_o == 0, "R3 byte_en frozen", byte_en_o, 0);
    row_close();
  endtask

  task automatic t_block();
    load_color(0, 0, 16'hBEEF);
    block_write(9'h002, 9'h00D, 0, 0, 8'hA5);
    for (int k = 8; k < 16; k++) do_read(9'h002, 9'(k), "R5 block fill");
    load_color(0, 1, 16'h1234);
    block_write(9'h003, 9'h01F, 1, 0, 8'h81);
    do_read(9'h003, 9'h018, "R8 colour lanes / R5 edge col");
    do_read(9'h003, 9'h019, "R5 unmasked col");
    do_read(9'h003, 9'h01F, "R5 last col");
    block_write(9'h000, 9'h000, 0, 1, 8'h01);
    do_read(9'h000, 9'h000, "R5 upper lane / R8");
  endtask

  task automatic t_xfer();
    row_open(9'h001, 0, 0, 1, 1, 1, 16'h0);
    chk(op_o == 5, "R10 xfer decode", op_o, 5);
    col_pulse(9'h1E5, 16'h5555);
    chk(col_o == 9'h1E5, "R10 tap col", col_o, 9'h1E5);
    chk(data_oe_o == 0, "R10 no oe", data_oe_o, 0);
    row_close();
    do_read(9'h001, 9'h005, "R10 array untouched");
  endtask

  initial begin
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 32; c++) ref_mem[r][c] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_write_read();
    t_frozen();
    t_block();
    t_xfer();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule